// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit binary down-counting timer channel driven through an 8-bit register port. Software programs it in three steps. It writes a control byte that selects the operating mode. It then writes the count as two bytes, low first. The channel starts counting on the high-byte write and decrements once for each pulse on a timebase tick enable, which is typically derived from a clock of about 1.19 MHz.

There are three modes. The one-shot mode raises an output level when the programmed time expires. The rate-generator and square-wave modes reload the counter and produce a one-cycle expiry pulse at every wrap. The count can be frozen into a holding register by a latch command and then read back as two bytes.

Control, count-write and count-read strobes are single-cycle enables. Read data is combinational from the current state, so it is valid in the same cycle as the read strobe.

Top module: `interval_timer_ch`

## Requirements
- R1: Control byte layout: bits [5:4] are the access field (00 = latch command, 11 = low-then-high byte access), bits [3:1] are the mode (0 = one-shot, 2 = rate generator, 3 = square wave), bit [0] selects BCD, and bits [7:6] are ignored. A valid control byte changes only the mode; it neither arms nor disarms the counter.
- R2: A control byte is rejected if its access field is 01 or 10, its mode is not 0, 2 or 3, or its BCD bit is set. A rejected byte sets `cfg_err`, which stays set until reset, and leaves the mode unchanged.
- R3: A latch command copies the live count into a holding register and points the read sequence at the low byte. A latch command issued while a latch is still pending has no effect. A latch issued in the same cycle as a tick captures the count from before that decrement.
- R4: Reads alternate between low byte and high byte, starting with the low byte. While a latch is pending, both bytes come from the holding register, and reading the high byte releases the latch. Otherwise the bytes come from the live count.
- R5: Count writes alternate between low byte and high byte. A low-byte write replaces bits [7:0] of the live count, disarms the counter and drives `out_level` low.
- R6: A high-byte write replaces bits [15:8] and computes a period: the written count in mode 0, or the written count minus one in modes 2 and 3. If the written count and the period are both non-zero, the counter is armed and the live count is loaded with the period. Otherwise the counter is not armed and the live count holds the written value. Arming happens on no other event.
- R7: While armed, the live count decrements by one on each cycle with `tick` high. A count write in the same cycle takes precedence over the tick.
- R8: In mode 0, the tick that finds the live count at 1 is the expiry tick. It sets the live count to 0, disarms the counter and raises `out_level`, which stays high until the next low-byte write.
- R9: In modes 2 and 3, the expiry tick reloads the live count with the period, and `expire_pulse` is high for exactly the one following cycle. `out_level` stays low in these modes.
- R10: A synchronous active-high reset clears the live count, the period, the holding register, both byte pointers, the latch flag, the mode, `out_level`, `expire_pulse` and `cfg_err`, and leaves the counter disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable, one decrement per high cycle |
| ctrl_wr | input | 1 | Control byte strobe |
| ctrl_data | input | 8 | Control byte |
| cnt_wr | input | 1 | Count byte write strobe |
| wr_data | input | 8 | Count byte to write |
| cnt_rd | input | 1 | Count byte read strobe |
| rd_data | output | 8 | Count byte read, valid in the strobe cycle |
| out_level | output | 1 | One-shot terminal-count level |
| expire_pulse | output | 1 | One-cycle wrap pulse in periodic modes |
| cfg_err | output | 1 | Sticky rejected-control-byte flag |

## Verification
Two pairs of events can land on the same edge. A latch command can coincide with a decrementing tick, and a low-byte write can coincide with the tick that would otherwise expire the count. Directed steps place each pair on one edge on purpose. The bench then reads back the latched bytes, or watches `out_level` and `expire_pulse` over the following ticks. The random phase draws the tick independently of the register operation so that these overlaps also recur with varied counts and modes. A bench model built from the requirements judges every read byte and output in those runs.

// File: rtl/interval_timer_ch.sv
module interval_timer_ch (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_data,
  input  logic       cnt_wr,
  input  logic [7:0] wr_data,
  input  logic       cnt_rd,
  output logic [7:0] rd_data,
  output logic       out_level,
  output logic       expire_pulse,
  output logic       cfg_err
);
  localparam logic [1:0] ACC_LATCH = 2'b00;
  localparam logic [1:0] ACC_LOHI  = 2'b11;

  logic [15:0] cnt, period, latch_val;
  logic [2:0]  mode;
  logic        armed, latch_on, rd_hi, wr_hi;

  wire [1:0]  acc       = ctrl_data[5:4];
  wire [2:0]  new_mode  = ctrl_data[3:1];
  wire        mode_ok   = (new_mode == 3'd0) || (new_mode == 3'd2) || (new_mode == 3'd3);
  wire        cfg_bad   = (acc != ACC_LOHI) || ctrl_data[0] || !mode_ok;
  wire        latch_cmd = ctrl_wr && (acc == ACC_LATCH);
  wire        cfg_cmd   = ctrl_wr && (acc != ACC_LATCH);
  wire        periodic  = (mode == 3'd2) || (mode == 3'd3);
  wire [15:0] new_cnt   = {wr_data, cnt[7:0]};
  wire [15:0] new_per   = periodic ? new_cnt - 16'd1 : new_cnt;
  wire        expire    = tick && armed && !cnt_wr && (cnt == 16'd1);
  wire [15:0] rd_src    = latch_on ? latch_val : cnt;

  assign rd_data = rd_hi ? rd_src[15:8] : rd_src[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; period <= '0; latch_val <= '0; mode <= '0;
      armed <= 1'b0; latch_on <= 1'b0; rd_hi <= 1'b0; wr_hi <= 1'b0;
      out_level <= 1'b0; expire_pulse <= 1'b0; cfg_err <= 1'b0;
    end else begin
      expire_pulse <= expire && periodic;

      if (cnt_wr) begin
        if (!wr_hi) begin
          cnt[7:0]  <= wr_data;
          armed     <= 1'b0;
          out_level <= 1'b0;
          wr_hi     <= 1'b1;
        end else begin
          wr_hi  <= 1'b0;
          period <= new_per;
          if (new_cnt != 16'd0 && new_per != 16'd0) begin
            armed <= 1'b1;
            cnt   <= new_per;
          end else begin
            cnt   <= new_cnt;
          end
        end
      end else if (expire) begin
        if (periodic) cnt <= period;
        else begin
          cnt       <= '0;
          armed     <= 1'b0;
          out_level <= 1'b1;
        end
      end else if (tick && armed) begin
        cnt <= cnt - 16'd1;
      end

      if (cfg_cmd) begin
        if (cfg_bad) cfg_err <= 1'b1;
        else         mode    <= new_mode;
      end

      if (latch_cmd && !latch_on) begin
        latch_on  <= 1'b1;
        latch_val <= cnt;
        rd_hi     <= 1'b0;
      end else if (cnt_rd) begin
        if (latch_on && rd_hi) latch_on <= 1'b0;
        rd_hi <= !rd_hi;
      end
    end
  end

  // R2
  p_err_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
  // R3
  p_latch_hold_r3: assert property (@(posedge clk) disable iff (rst)
    latch_on |=> (!latch_on || $stable(latch_val)));
  // R5
  p_low_write_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && !wr_hi) |=> (!armed && !out_level));
  // R6
  p_arm_on_high_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(cnt_wr && wr_hi));
  // R7
  p_armed_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    armed |-> (cnt != 16'd0));
  // R8
  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_level && !(cnt_wr && !wr_hi)) |=> out_level);
  // R9
  p_pulse_low_r9: assert property (@(posedge clk) disable iff (rst)
    expire_pulse |-> !out_level);
endmodule

// File: tb/interval_timer_ch_bench.sv
module interval_timer_ch_bench;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, ctrl_wr = 1'b0, cnt_wr = 1'b0, cnt_rd = 1'b0;
  logic [7:0] ctrl_data = '0, wr_data = '0;
  logic [7:0] rd_data;
  logic out_level, expire_pulse, cfg_err;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  interval_timer_ch u_interval_timer_ch (
    .clk(clk), .rst(rst), .tick(tick), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .cnt_wr(cnt_wr), .wr_data(wr_data), .cnt_rd(cnt_rd), .rd_data(rd_data),
    .out_level(out_level), .expire_pulse(expire_pulse), .cfg_err(cfg_err));

  always #5 clk = ~clk;

  logic [15:0] m_cnt, m_per, m_lv;
  logic [2:0]  m_mode;
  bit m_arm, m_out, m_pulse, m_err, m_lat, m_rh, m_wh;

  function automatic logic [7:0] exp_rd();
    logic [15:0] s = m_lat ? m_lv : m_cnt;
    return m_rh ? s[15:8] : s[7:0];
  endfunction

  function automatic bit per_mode(input logic [2:0] md);
    return md == 3'd2 || md == 3'd3;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_per = 0; m_lv = 0; m_mode = 0;
    m_arm = 0; m_out = 0; m_pulse = 0; m_err = 0; m_lat = 0; m_rh = 0; m_wh = 0;
  endtask

  // op: 0 idle, 1 control, 2 count write, 3 count read
  task automatic step(input bit tk, input int op, input logic [7:0] d);
    logic [15:0] old, nc, np;
    @(negedge clk);
    tick = tk; ctrl_wr = (op == 1); cnt_wr = (op == 2); cnt_rd = (op == 3);
    ctrl_data = d; wr_data = d;
    #1;
    if (op == 3) chk("R4 read byte", rd_data, exp_rd());
    @(posedge clk);
    old = m_cnt;
    m_pulse = 0;
    if (op == 2) begin
      if (!m_wh) begin
        m_cnt[7:0] = d; m_arm = 0; m_out = 0; m_wh = 1;
      end else begin
        m_wh = 0;
        nc = {d, m_cnt[7:0]};
        np = per_mode(m_mode) ? nc - 16'd1 : nc;
        m_per = np;
        if (nc != 0 && np != 0) begin m_arm = 1; m_cnt = np; end
        else m_cnt = nc;
      end
    end else if (tk && m_arm) begin
      if (m_cnt == 16'd1) begin
        if (per_mode(m_mode)) begin m_cnt = m_per; m_pulse = 1; end
        else begin m_cnt = 0; m_arm = 0; m_out = 1; end
      end else m_cnt = m_cnt - 16'd1;
    end
    if (op == 1) begin
      if (d[5:4] == 2'b00) begin
        if (!m_lat) begin m_lat = 1; m_lv = old; m_rh = 0; end
      end else if (d[5:4] != 2'b11 || d[0] || !(d[3:1] == 0 || d[3:1] == 2 || d[3:1] == 3))
        m_err = 1;
      else m_mode = d[3:1];
    end
    if (op == 3) begin
      if (m_lat && m_rh) begin m_lat = 0; m_rh = 0; end
      else m_rh = !m_rh;
    end
    #1;
    chk("R8 out_level", out_level, m_out);
    chk("R9 expire_pulse", expire_pulse, m_pulse);
    chk("R2 cfg_err", cfg_err, m_err);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 0, 8'h00);
  endtask

  task automatic prog(input logic [15:0] v);
    step(1'b0, 2, v[7:0]);
    step(1'b0, 2, v[15:8]);
  endtask

  task automatic read_word(input string tag, input logic [15:0] exp);
    logic [7:0] lo, hi;
    step(1'b0, 3, 8'h00); lo = u_rd_lo;
    step(1'b0, 3, 8'h00); hi = u_rd_lo;
    chk(tag, {hi, lo}, exp);
  endtask

  logic [7:0] u_rd_lo;
  always @(negedge clk) #2 u_rd_lo = rd_data;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0254));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R10 reset state
    chk("R10 out_level", out_level, 0);
    chk("R10 expire_pulse", expire_pulse, 0);
    chk("R10 cfg_err", cfg_err, 0);
    read_word("R10 count after reset", 16'h0000);

    // R1: select bits ignored, mode 0
    step(1'b0, 1, 8'hB0);
    chk("R1 select ignored", cfg_err, 0);
    prog(16'h0005);
    read_word("R6 live count loaded", 16'h0005);
    ticks(4);
    read_word("R7 decremented count", 16'h0001);
    chk("R8 low before expiry", out_level, 0);
    ticks(1);
    chk("R8 high at expiry", out_level, 1);
    ticks(3);
    chk("R8 holds high", out_level, 1);
    read_word("R8 count zero after expiry", 16'h0000);

    // R5: low byte write clears out, disarms
    step(1'b0, 2, 8'h07);
    chk("R5 out cleared", out_level, 0);
    read_word("R5 low byte replaced", 16'h0007);
    step(1'b0, 2, 8'h00);
    ticks(6);
    // R7: low write wins over expiring tick
    step(1'b1, 2, 8'h09);
    ticks(3);
    chk("R7 write beat expiry", out_level, 0);
    read_word("R5 disarmed count frozen", 16'h0009);
    step(1'b0, 2, 8'h00);

    // R9: rate generator, period 3
    step(1'b0, 1, 8'h34);
    prog(16'h0004);
    read_word("R6 periodic period", 16'h0003);
    ticks(2);
    chk("R9 no pulse early", expire_pulse, 0);
    ticks(1);
    chk("R9 pulse at wrap", expire_pulse, 1);
    ticks(1);
    chk("R9 pulse one cycle", expire_pulse, 0);
    ticks(2);
    chk("R9 second wrap", expire_pulse, 1);

    // R6: zero period not armed
    prog(16'h0001);
    ticks(5);
    read_word("R6 zero period unarmed", 16'h0001);

    // R3/R4: latch coinciding with tick
    prog(16'h0104);
    ticks(2);
    step(1'b1, 1, 8'h00);
    ticks(2);
    step(1'b0, 1, 8'h00);
    read_word("R3 latched value", 16'h0101);
    read_word("R4 live after release", 16'h00FE);

    // R2: invalid words rejected, mode stays 2
    step(1'b0, 1, 8'h32);
    chk("R2 bad mode flagged", cfg_err, 1);
    step(1'b0, 1, 8'h31);
    step(1'b0, 1, 8'h10);
    prog(16'h0003);
    ticks(2);
    chk("R2 mode unchanged", expire_pulse, 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit tk = ($urandom % 2) == 1;
      int op = $urandom % 6;
      logic [7:0] d;
      if (op > 3) op = 0;
      if (op == 1) begin
        case ($urandom % 6)
          0: d = 8'h30;
          1: d = 8'h34;
          2: d = 8'h36;
          3, 4: d = 8'h00;
          default: d = 8'($urandom);
        endcase
      end else if (op == 2) d = m_wh ? 8'($urandom % 2) : 8'($urandom % 24);
      else d = 8'h00;
      step(tk, op, d);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule